// File: doc/BRIEF.md
# Console Terminal Register Port

This block is the register-side face of a console terminal. A host bus decoder (outside the block) presents single-cycle reads and writes on four word addresses: a receive status word, a receive data word, a transmit status word and a transmit data word. Characters from a byte-wide serial receiver arrive on a strobe and are latched for software to collect. Characters written by software leave through a valid/acknowledge handshake toward a serial transmitter. Each direction keeps a completion flag and an interrupt-enable bit, and drives its own interrupt request.

The transmit data word carries a four-bit unit field in bits 11:8. A zero there means an ordinary terminal character. Any other value suppresses output. When the field is all ones, the low byte is decoded as a console mailbox command that can pulse a software-done or a reboot line.

Address map (regAddr): 0 = receive status, 1 = receive data, 2 = transmit status, 3 = transmit data. In both status words bit 7 is the completion flag (DONE) and bit 6 is the interrupt enable (IE).

Top module: `conTermPort`

## Requirements
- R1: After reset the transmit DONE flag is 1. Receive DONE, both IE bits, the receive data word and both interrupt requests are 0, and txValid is low.
- R2: A status read returns DONE in bit 7 and IE in bit 6 with every other bit 0. A status write changes only IE, taken from bit 6 of the write data.
- R3: A status write with bit 6 = 0 drops that side's interrupt request on the next cycle. A write with bit 6 = 1 while DONE is set and IE was clear raises the request on the next cycle.
- R4: A receive strobe without break loads the data word with {8'h00, rxChar} and sets receive DONE, and raises rxIrq when IE is set. A strobe that arrives while DONE is still set overwrites the earlier character, and no overrun indication exists.
- R5: A receive strobe with rxBreak high loads the data word with 16'h8000, which is the error flag in bit 15.
- R6: A receive data read returns the stored word. If DONE was set, the read clears DONE, clears bits 15:8 of the stored word and drops rxIrq. A read while DONE is clear changes nothing.
- R7: A transmit data write in idle stores all 16 bits, which read back at address 3, clears transmit DONE and drops txIrq. With unit field 0, txValid rises with txData equal to the low byte, and both are held stable until txAck. DONE is set on the edge that samples txAck, and txIrq is raised then if IE is set.
- R8: A transmit data write with a nonzero unit field never asserts txValid. It sets transmit DONE on the second edge after the write.
- R9: With unit field 4'hF, low byte 8'h01 pulses mbxSwDone and low byte 8'h02 pulses mbxReboot, each for one cycle starting at the edge after the write. Any other function code (3 or 4 among them) and any other nonzero unit field produce no pulse.
- R10: A transmit data write made while a previous character is still waiting for txAck is ignored: no second character is sent and the stored word is unchanged.
- R11: An interrupt request is only ever high while its side has both DONE and IE set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle |
| regRdEn | input | 1 | Register read strobe, one cycle (its side effects apply at the edge) |
| regAddr | input | 2 | Register word address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr, combinational |
| rxStrobe | input | 1 | A received character is present this cycle |
| rxChar | input | 8 | Received character |
| rxBreak | input | 1 | The received item is a break condition |
| txValid | output | 1 | A character is offered to the transmitter |
| txData | output | 8 | Offered character |
| txAck | input | 1 | The transmitter has taken the character |
| rxIrq | output | 1 | Receive interrupt request |
| txIrq | output | 1 | Transmit interrupt request |
| mbxSwDone | output | 1 | Mailbox software-done pulse |
| mbxReboot | output | 1 | Mailbox reboot pulse |

## Verification
A DONE flag that is wrong inside the block shows in the next status read. It also shows within one cycle on the interrupt line whenever IE is set. A transmit sequencer stuck in the wrong state shows as a missing or extra character on txValid, which the scoreboard catches at the acknowledge point, or as a DONE flag that never returns. A mailbox decode error appears as an unexpected or missing one-cycle pulse right after the write. A receive buffer that keeps its error bit or its high byte after the first read shows on the second read.

// File: rtl/conTermPkg.sv
package conTermPkg;
  localparam int DATA_W   = 16;
  localparam int CHAR_W   = 8;
  localparam int SEL_LSB  = 8;
  localparam int SEL_W    = 4;
  localparam int DONE_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int ERR_BIT  = 15;
  localparam int SIDES    = 2;
  localparam logic [SEL_W-1:0]  SEL_TERM  = '0;
  localparam logic [SEL_W-1:0]  SEL_MBX   = '1;
  localparam logic [CHAR_W-1:0] FN_SWDONE = CHAR_W'(1);
  localparam logic [CHAR_W-1:0] FN_REBOOT = CHAR_W'(2);

  typedef enum logic [1:0] {
    ADDR_RX_CSR  = 2'd0,
    ADDR_RX_DATA = 2'd1,
    ADDR_TX_CSR  = 2'd2,
    ADDR_TX_DATA = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic rxCsrWr;
    logic rxBufRd;
    logic rxLoad;
    logic txCsrWr;
    logic txLoad;
    logic txFinish;
    logic ieVal;
  } ctStrobe_t;
endpackage

// File: rtl/conTermFlagCell.sv
// One side's DONE / IE / interrupt-request triple.
module conTermFlagCell #(
  parameter bit DONE_INIT = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic csrWr,
  input  logic ieVal,
  input  logic setEvt,
  input  logic clrEvt,
  output logic done,
  output logic ie,
  output logic irq
);
  logic ieEff;
  logic irqNext;

  assign ieEff = csrWr ? ieVal : ie;

  always_comb begin
    if (csrWr && !ieVal)                  irqNext = 1'b0;
    else if (setEvt && ieEff)             irqNext = 1'b1;
    else if (csrWr && ieVal && !ie && done) irqNext = 1'b1;
    else if (clrEvt)                      irqNext = 1'b0;
    else                                  irqNext = irq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done <= DONE_INIT;
      ie   <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (setEvt)      done <= 1'b1;
      else if (clrEvt) done <= 1'b0;
      if (csrWr) ie <= ieVal;
      irq <= irqNext;
    end
  end
endmodule

// File: rtl/conTermCtrl.sv
// Register decode, transmit sequencing and mailbox decode.
module conTermCtrl
  import conTermPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [CHAR_W-1:0] wrFunc,
  input  logic              wrIe,
  input  logic              rxStrobe,
  input  logic              txAck,
  output ctStrobe_t         strobe,
  output logic              txBusy,
  output logic              mbxSwDone,
  output logic              mbxReboot
);
  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_MBX} txState_e;

  txState_e txState;
  regAddr_e addrE;
  logic     txDataWr;
  logic     txLoad;
  logic     txFinish;
  logic     isMbx;

  assign addrE    = regAddr_e'(regAddr);
  assign txDataWr = regWrEn && (addrE == ADDR_TX_DATA);
  assign txLoad   = txDataWr && (txState == TX_IDLE);
  assign txFinish = ((txState == TX_WAIT) && txAck) || (txState == TX_MBX);
  assign isMbx    = (wrSel == SEL_MBX);

  always_comb begin
    strobe          = '0;
    strobe.rxCsrWr  = regWrEn && (addrE == ADDR_RX_CSR);
    strobe.txCsrWr  = regWrEn && (addrE == ADDR_TX_CSR);
    strobe.rxBufRd  = regRdEn && (addrE == ADDR_RX_DATA);
    strobe.rxLoad   = rxStrobe;
    strobe.txLoad   = txLoad;
    strobe.txFinish = txFinish;
    strobe.ieVal    = wrIe;
  end

  assign txBusy = (txState == TX_WAIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState   <= TX_IDLE;
      mbxSwDone <= 1'b0;
      mbxReboot <= 1'b0;
    end else begin
      mbxSwDone <= txLoad && isMbx && (wrFunc == FN_SWDONE);
      mbxReboot <= txLoad && isMbx && (wrFunc == FN_REBOOT);
      unique case (txState)
        TX_IDLE: if (txLoad) txState <= (wrSel == SEL_TERM) ? TX_WAIT : TX_MBX;
        TX_WAIT: if (txAck)  txState <= TX_IDLE;
        TX_MBX:              txState <= TX_IDLE;
        default:             txState <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conTermDp.sv
// Data words, flag cells and read multiplexer.
module conTermDp
  import conTermPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctStrobe_t         strobe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              rxBreak,
  output logic [DATA_W-1:0] regRdData,
  output logic [CHAR_W-1:0] txChar,
  output logic              rxDone,
  output logic              rxIe,
  output logic              txDone,
  output logic              txIe,
  output logic              rxIrq,
  output logic              txIrq
);
  logic [DATA_W-1:0] rxBuf;
  logic [DATA_W-1:0] txBuf;
  logic [SIDES-1:0]  csrWrV, setV, clrV, doneV, ieV, irqV;

  // side 0 = receive, side 1 = transmit
  assign csrWrV = {strobe.txCsrWr, strobe.rxCsrWr};
  assign setV   = {strobe.txFinish, strobe.rxLoad};
  assign clrV   = {strobe.txLoad, strobe.rxBufRd && doneV[0]};

  for (genvar s = 0; s < SIDES; s++) begin : gSide
    conTermFlagCell #(.DONE_INIT(s == 1)) uCell (
      .clk   (clk),
      .rstN  (rstN),
      .csrWr (csrWrV[s]),
      .ieVal (strobe.ieVal),
      .setEvt(setV[s]),
      .clrEvt(clrV[s]),
      .done  (doneV[s]),
      .ie    (ieV[s]),
      .irq   (irqV[s])
    );
  end

  assign rxDone = doneV[0];
  assign txDone = doneV[1];
  assign rxIe   = ieV[0];
  assign txIe   = ieV[1];
  assign rxIrq  = irqV[0];
  assign txIrq  = irqV[1];

  function automatic logic [DATA_W-1:0] csrWord(input logic d, input logic e);
    logic [DATA_W-1:0] w;
    w = '0;
    w[DONE_BIT] = d;
    w[IE_BIT]   = e;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBuf <= '0;
      txBuf <= '0;
    end else begin
      if (strobe.rxLoad) begin
        if (rxBreak) begin
          rxBuf          <= '0;
          rxBuf[ERR_BIT] <= 1'b1;
        end else begin
          rxBuf <= DATA_W'(rxChar);
        end
      end else if (strobe.rxBufRd && rxDone) begin
        rxBuf <= DATA_W'(rxBuf[CHAR_W-1:0]);
      end
      if (strobe.txLoad) txBuf <= regWrData;
    end
  end

  always_comb begin
    unique case (regAddr_e'(regAddr))
      ADDR_RX_CSR:  regRdData = csrWord(rxDone, rxIe);
      ADDR_RX_DATA: regRdData = rxBuf;
      ADDR_TX_CSR:  regRdData = csrWord(txDone, txIe);
      ADDR_TX_DATA: regRdData = txBuf;
      default:      regRdData = '0;
    endcase
  end

  assign txChar = txBuf[CHAR_W-1:0];
endmodule

// File: rtl/conTermPort.sv
module conTermPort
  import conTermPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rxStrobe,
  input  logic [CHAR_W-1:0] rxChar,
  input  logic              rxBreak,
  output logic              txValid,
  output logic [CHAR_W-1:0] txData,
  input  logic              txAck,
  output logic              rxIrq,
  output logic              txIrq,
  output logic              mbxSwDone,
  output logic              mbxReboot
);
  ctStrobe_t strobe;
  logic rxDone, rxIe, txDone, txIe;

  conTermCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .wrSel    (regWrData[SEL_LSB +: SEL_W]),
    .wrFunc   (regWrData[CHAR_W-1:0]),
    .wrIe     (regWrData[IE_BIT]),
    .rxStrobe (rxStrobe),
    .txAck    (txAck),
    .strobe   (strobe),
    .txBusy   (txValid),
    .mbxSwDone(mbxSwDone),
    .mbxReboot(mbxReboot)
  );

  conTermDp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .rxChar   (rxChar),
    .rxBreak  (rxBreak),
    .regRdData(regRdData),
    .txChar   (txData),
    .rxDone   (rxDone),
    .rxIe     (rxIe),
    .txDone   (txDone),
    .txIe     (txIe),
    .rxIrq    (rxIrq),
    .txIrq    (txIrq)
  );
endmodule

// File: rtl/conTermChecker.sv
module conTermChecker (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic       wrIe,
  input logic       rxStrobe,
  input logic       txValid,
  input logic [7:0] txData,
  input logic       txAck,
  input logic       rxIrq,
  input logic       txIrq,
  input logic       rxDone,
  input logic       rxIe,
  input logic       txDone,
  input logic       txIe,
  input logic       mbxSwDone,
  input logic       mbxReboot
);
  assert_rx_irq_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> (rxDone && rxIe));
  assert_tx_irq_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> (txDone && txIe));
  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txAck) |=> (txValid && $stable(txData)));
  assert_busy_not_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !txDone);
  assert_mbx_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mbxSwDone, mbxReboot}));
  assert_rx_load_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> rxDone);
  assert_ie_off_drops_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0 && !wrIe) |=> !rxIrq);
endmodule

bind conTermPort conTermChecker uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .wrIe     (regWrData[6]),
  .rxStrobe (rxStrobe),
  .txValid  (txValid),
  .txData   (txData),
  .txAck    (txAck),
  .rxIrq    (rxIrq),
  .txIrq    (txIrq),
  .rxDone   (rxDone),
  .rxIe     (rxIe),
  .txDone   (txDone),
  .txIe     (txIe),
  .mbxSwDone(mbxSwDone),
  .mbxReboot(mbxReboot)
);

// File: tb/tb_conTermPort.sv
`timescale 1ns/1ps
module tb_conTermPort;
  logic        clk = 1'b0;
  logic        rstN, regWrEn, regRdEn, rxStrobe, rxBreak, txAck;
  logic [1:0]  regAddr;
  logic [15:0] regWrData, regRdData;
  logic [7:0]  rxChar, txData;
  logic        txValid, rxIrq, txIrq, mbxSwDone, mbxReboot;

  int passCnt = 0, totalCnt = 0, ackCnt = 0;
  bit finished = 0;
  logic [7:0] txQ[$];
  int         mbxQ[$];

  always #2 clk = ~clk;

  conTermPort dut (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    totalCnt++;
    if (act === exp) passCnt++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  // all tasks start and end at a falling edge
  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [15:0] d);
    regRdEn = 1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic rxSend(logic [7:0] c, logic brk);
    rxStrobe = 1; rxChar = c; rxBreak = brk;
    @(negedge clk);
    rxStrobe = 0; rxBreak = 0;
  endtask

  // driver: predicts what the block must produce, then writes
  task automatic txSend(logic [15:0] d);
    if (d[11:8] == 4'h0) txQ.push_back(d[7:0]);
    else if (d[11:8] == 4'hF && (d[7:0] == 8'h01 || d[7:0] == 8'h02)) mbxQ.push_back(int'(d[7:0]));
    regWrite(2'd3, d);
  endtask

  task automatic waitTxDone();
    logic [15:0] v;
    for (int i = 0; i < 20; i++) begin
      regRead(2'd2, v);
      if (v[7]) break;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // transmitter model and character monitor
  always @(negedge clk) begin
    if (txAck) begin
      txAck = 0; ackCnt = 0;
    end else if (txValid && rstN) begin
      ackCnt++;
      if (ackCnt >= 2) begin
        txAck = 1;
        if (txQ.size() == 0) chk("R8/R10 unexpected char", {8'h0, txData}, 16'hxxxx);
        else chk("R7 scoreboard char", {8'h0, txData}, {8'h0, txQ.pop_front()});
      end
    end
  end

  // mailbox monitor
  always @(negedge clk) begin
    if (rstN && (mbxSwDone || mbxReboot)) begin
      logic [15:0] got;
      got = mbxSwDone ? 16'd1 : 16'd2;
      if (mbxQ.size() == 0) chk("R9 unexpected mailbox pulse", got, 16'd0);
      else chk("R9 mailbox pulse", got, 16'(mbxQ.pop_front()));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      totalCnt++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rstN = 0; regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    rxStrobe = 0; rxChar = 0; rxBreak = 0; txAck = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    regRead(2'd0, v); chk("R1 rx csr", v, 16'h0000);
    regRead(2'd1, v); chk("R1 rx data", v, 16'h0000);
    regRead(2'd2, v); chk("R1 tx csr", v, 16'h0080);
    chk("R1 irqs/valid", {13'h0, rxIrq, txIrq, txValid}, 16'h0);

    // R2 only IE writable, only DONE/IE read
    regWrite(2'd0, 16'hFFFF);
    regRead(2'd0, v); chk("R2 rx csr mask", v, 16'h0040);
    chk("R3 rx irq stays low without done", {15'h0, rxIrq}, 16'h0);
    regWrite(2'd2, 16'hFFBF);
    regRead(2'd2, v); chk("R2 tx ie not set by other bits", v, 16'h0080);
    regWrite(2'd2, 16'h0040);
    chk("R3 tx irq on ie rise with done", {15'h0, txIrq}, 16'h1);
    regRead(2'd2, v); chk("R2 tx csr", v, 16'h00C0);
    regWrite(2'd2, 16'h0000);
    chk("R3 tx irq drop on ie clear", {15'h0, txIrq}, 16'h0);

    // R4 / R6 receive path with IE set
    rxSend(8'h41, 0);
    chk("R4 rx irq", {15'h0, rxIrq}, 16'h1);
    regRead(2'd0, v); chk("R4 rx done", v, 16'h00C0);
    regRead(2'd1, v); chk("R6 rx data", v, 16'h0041);
    chk("R6 irq dropped by read", {15'h0, rxIrq}, 16'h0);
    regRead(2'd0, v); chk("R6 done cleared", v, 16'h0040);
    regRead(2'd1, v); chk("R6 reread no effect", v, 16'h0041);

    // R5 break
    rxSend(8'h5A, 1);
    regRead(2'd1, v); chk("R5 break word", v, 16'h8000);
    regRead(2'd1, v); chk("R6 error bit cleared", v, 16'h0000);

    // R4 overwrite, no overrun
    rxSend(8'h78, 0);
    rxSend(8'h79, 0);
    regRead(2'd0, v); chk("R4 overwrite csr", v, 16'h00C0);
    regRead(2'd1, v); chk("R4 overwrite data", v, 16'h0079);

    // R3 IE enabled late
    regWrite(2'd0, 16'h0000);
    rxSend(8'h31, 0);
    chk("R4 no irq when IE clear", {15'h0, rxIrq}, 16'h0);
    regWrite(2'd0, 16'h0040);
    chk("R3 irq on late enable", {15'h0, rxIrq}, 16'h1);
    regWrite(2'd0, 16'h0000);
    chk("R3 irq dropped", {15'h0, rxIrq}, 16'h0);
    regRead(2'd1, v);

    // R7 transmit terminal char
    regWrite(2'd2, 16'h0040);
    txSend(16'h0055);
    chk("R7 irq dropped on write", {15'h0, txIrq}, 16'h0);
    chk("R7 valid", {15'h0, txValid}, 16'h1);
    chk("R7 data", {8'h0, txData}, 16'h0055);
    waitTxDone();
    chk("R7 irq on completion", {15'h0, txIrq}, 16'h1);
    regRead(2'd3, v); chk("R7 stored word", v, 16'h0055);

    // R10 write while busy ignored
    txSend(16'h0066);
    regWrite(2'd3, 16'h0077);   // must produce nothing
    waitTxDone();
    idle(4);
    chk("R10 no extra valid", {15'h0, txValid}, 16'h0);
    regRead(2'd3, v); chk("R10 word unchanged", v, 16'h0066);

    // R8 nonzero unit, no output
    txSend(16'h0341);
    chk("R8 no valid", {15'h0, txValid}, 16'h0);
    regRead(2'd2, v); chk("R8 done cleared", v, 16'h0040);
    regRead(2'd2, v); chk("R8 done set", v, 16'h00C0);
    chk("R8 irq", {15'h0, txIrq}, 16'h1);

    // R9 mailbox
    txSend(16'h0F01); idle(2);
    txSend(16'h0F02); idle(2);
    txSend(16'h0F03); idle(2);
    txSend(16'h0F04); idle(2);
    txSend(16'h0701); idle(3);
    chk("R9 no valid for mailbox", {15'h0, txValid}, 16'h0);

    idle(4);
    chk("R7 char queue drained", 16'(txQ.size()), 16'h0);
    chk("R9 mailbox queue drained", 16'(mbxQ.size()), 16'h0);
    finished = 1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule